// File: doc/BRIEF.md
# Dual-Mode Phase Controller for Burst Clock Recovery

This block is the digital loop filter and phase selector of a burst-mode clock and data recovery loop. Each clock it takes one early/late decision per lane from a bang-bang phase detector that samples four parallel lanes at quarter rate. It folds the lanes into one net direction and steers a 5-bit phase interpolator code. The code has 32 positions per unit interval.

A burst start, or the synchronous reset, puts the controller in search mode at mid-code. It then runs a binary search whose step halves at every decision. Before each decision it waits a settle interval, so that the interpolator has time to follow the last code change. Once the unit step has been applied, the controller switches by itself to tracking mode. In tracking mode it moves the code one position at a time, and only after a run of votes that agree. The code wraps around the unit-interval boundary instead of stopping at the ends.

The vote input is a valid/ready stream. `vote_ready` is always high, so the block never applies back-pressure. A beat is consumed on every cycle in which `vote_valid` is high. A consumed beat may still have no effect: this happens while the settle interval runs, and on a tie.

Top module: `cdr_phase_ctrl`

## Requirements
- R1: Every consumed beat is reduced to one direction. The number of lanes with `lane_early` set is compared with the number of lanes with `lane_late` set. More early lanes gives "up", which is code plus a step. More late lanes gives "down", which is code minus a step. Equal counts, including no lanes set at all, give "none", and "none" never changes the code.
- R2: `vote_ready` is always 1. A beat with `vote_valid` low has no effect on the code, on the search progress or on the tracking run count.
- R3: When `rst_n` is low or `burst_start` is high at a clock edge, after that edge `pi_code` is 16, `locked` is 0 and `tracking` is 0 (search mode).
- R4: In search mode the decisions apply steps of 8, 4, 2 and 1 in that order. Each decision adds or subtracts the current step according to the R1 direction.
- R5: A search decision is only taken at an edge that comes at least SETTLE (default 2) edges after the last restart or code change. Any beat consumed earlier has no effect. With votes valid and non-tied on every cycle, `locked` rises at the 4*(SETTLE+1)-th edge (the 12th) after the restart edge.
- R6: The edge that applies the unit step sets `tracking` and `locked`. Both then stay 1 until the next restart.
- R7: In tracking mode the code changes by exactly one position, and only on the RUN_LEN-th (default 4) consecutive consumed beat with the same direction. A beat with the opposite direction starts a new run of length one. Ties and invalid beats neither advance a run nor break it. The run count is zero when tracking begins.
- R8: In tracking mode the code wraps modulo 32: 31 plus one gives 0, and 0 minus one gives 31.
- R9: In search mode a tie consumes the beat without taking a decision. The step stays where it is, and the search waits for a beat with a direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | Restarts acquisition at the next edge |
| vote_valid | input | 1 | Lane decisions on this cycle are valid |
| vote_ready | output | 1 | Always 1; the block never stalls |
| lane_early | input | 4 | Per-lane early decision |
| lane_late | input | 4 | Per-lane late decision |
| pi_code | output | 5 | Phase interpolator code, 32 steps per UI |
| locked | output | 1 | Set when tracking begins, held until restart |
| tracking | output | 1 | 0 = binary search, 1 = linear tracking |

## Verification
The bench sweeps all 32 target phases through a phase model. For each one it checks the exact code the search ends on and the exact edge at which lock rises. A controller that samples votes during the settle window would lock early. One that halves the step in the wrong order would land on the wrong code. Directed sequences then go after the run filter. They check that an opposite vote restarts the run while ties and invalid beats leave it alone, that the code wraps in both directions at the 31/0 boundary, and that search ties stall the search. A design that let ties or gaps break runs would step late. One that saturated at the code ends would stick at 31 or at 0.

// File: rtl/cdr_pc_pkg.sv
package cdr_pc_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10
  } dir_t;
endpackage

// File: rtl/cdr_vote_merge.sv
// Reduces per-lane early/late flags to a single net direction.
module cdr_vote_merge
  import cdr_pc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             valid,
  input  logic [LANES-1:0] early,
  input  logic [LANES-1:0] late,
  output dir_t             dir
);
  localparam int CW = $clog2(LANES + 1);

  logic [CW-1:0] n_early, n_late;

  always_comb begin
    n_early = '0;
    n_late  = '0;
    for (int i = 0; i < LANES; i++) begin
      n_early = n_early + CW'(early[i]);
      n_late  = n_late  + CW'(late[i]);
    end
    if (!valid || n_early == n_late) dir = DIR_NONE;
    else if (n_early > n_late)       dir = DIR_UP;
    else                             dir = DIR_DN;
  end
endmodule

// File: rtl/cdr_settle_timer.sv
// Counts down after each load; settled once the count reaches zero.
module cdr_settle_timer #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic load,
  output logic settled
);
  localparam int CW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)           cnt <= CW'(SETTLE);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign settled = (cnt == '0);
endmodule

// File: rtl/cdr_run_filter.sv
// Emits a single step pulse after RUN_LEN consecutive same-direction votes.
module cdr_run_filter
  import cdr_pc_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic clear,
  input  logic en,
  input  dir_t dir,
  output logic step_up,
  output logic step_dn
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt, cnt_nxt;
  dir_t          last;
  logic          fire;

  always_comb begin
    cnt_nxt = (dir == last) ? cnt + 1'b1 : CW'(1);
    fire    = en && (dir != DIR_NONE) && (cnt_nxt == CW'(RUN_LEN));
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt  <= '0;
      last <= DIR_NONE;
    end else if (en && dir != DIR_NONE) begin
      cnt  <= fire ? '0 : cnt_nxt;
      last <= dir;
    end
  end

  assign step_up = fire && (dir == DIR_UP);
  assign step_dn = fire && (dir == DIR_DN);
endmodule

// File: rtl/cdr_phase_ctrl.sv
// Binary-search acquisition followed by unit-step tracking of a PI code.
module cdr_phase_ctrl
  import cdr_pc_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int CODE_W  = 5,
  parameter int SETTLE  = 2,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_start,
  input  logic              vote_valid,
  output logic              vote_ready,
  input  logic [LANES-1:0]  lane_early,
  input  logic [LANES-1:0]  lane_late,
  output logic [CODE_W-1:0] pi_code,
  output logic              locked,
  output logic              tracking
);
  localparam int                CODE_N = 1 << CODE_W;
  localparam logic [CODE_W-1:0] MID    = CODE_W'(CODE_N / 2);
  localparam logic [CODE_W-1:0] FIRST  = CODE_W'(CODE_N / 4);

  dir_t              dir;
  logic              restart, settled, take, trk_up, trk_dn;
  logic [CODE_W-1:0] step;

  assign restart    = !rst_n || burst_start;
  assign take       = !tracking && settled && (dir != DIR_NONE);
  assign vote_ready = 1'b1;

  cdr_vote_merge #(.LANES(LANES)) u_merge (
    .valid (vote_valid),
    .early (lane_early),
    .late  (lane_late),
    .dir   (dir)
  );

  cdr_settle_timer #(.SETTLE(SETTLE)) u_settle (
    .clk     (clk),
    .load    (restart || take),
    .settled (settled)
  );

  cdr_run_filter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .clear   (restart || !tracking),
    .en      (tracking),
    .dir     (dir),
    .step_up (trk_up),
    .step_dn (trk_dn)
  );

  always_ff @(posedge clk) begin
    if (restart) begin
      pi_code  <= MID;
      step     <= FIRST;
      tracking <= 1'b0;
      locked   <= 1'b0;
    end else if (!tracking) begin
      if (take) begin
        pi_code <= (dir == DIR_UP) ? pi_code + step : pi_code - step;
        step    <= step >> 1;
        if (step == CODE_W'(1)) begin
          tracking <= 1'b1;
          locked   <= 1'b1;
        end
      end
    end else begin
      if (trk_up)      pi_code <= pi_code + 1'b1;
      else if (trk_dn) pi_code <= pi_code - 1'b1;
    end
  end
endmodule

// File: rtl/cdr_phase_ctrl_chk.sv
// Port-level temporal checks for cdr_phase_ctrl.
module cdr_phase_ctrl_chk #(
  parameter int CODE_W = 5,
  parameter int SETTLE = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_start,
  input logic              vote_valid,
  input logic [CODE_W-1:0] pi_code,
  input logic              locked,
  input logic              tracking
);
  localparam int                QW  = $clog2(SETTLE + 1) + 1;
  localparam logic [CODE_W-1:0] MID = CODE_W'((1 << CODE_W) / 2);

  logic              seen;
  logic [CODE_W-1:0] prev, delta, ndelta;
  logic [QW-1:0]     quiet;
  logic              chg;

  assign chg    = seen && (pi_code != prev);
  assign delta  = pi_code - prev;
  assign ndelta = prev - pi_code;

  always_ff @(posedge clk) begin
    seen <= rst_n;
    prev <= pi_code;
    if (!rst_n || burst_start)     quiet <= '0;
    else if (chg)                  quiet <= QW'(1);
    else if (quiet < QW'(SETTLE))  quiet <= quiet + 1'b1;
  end

  assert_restart_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> (pi_code == MID && !locked && !tracking));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !burst_start) |=> locked);

  assert_lock_with_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> tracking);

  assert_search_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !$past(tracking) && !$past(burst_start))
      |-> ($countones(delta) == 1 || $countones(ndelta) == 1));

  assert_track_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && $past(tracking) && !$past(burst_start))
      |-> (delta == CODE_W'(1) || ndelta == CODE_W'(1)));

  assert_settle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !$past(tracking) && !$past(burst_start)) |-> ($past(quiet) >= QW'(SETTLE)));

  assert_valid_needed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !$past(burst_start)) |-> $past(vote_valid));
endmodule

bind cdr_phase_ctrl cdr_phase_ctrl_chk #(.CODE_W(CODE_W), .SETTLE(SETTLE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .burst_start (burst_start),
  .vote_valid  (vote_valid),
  .pi_code     (pi_code),
  .locked      (locked),
  .tracking    (tracking)
);

// File: tb/test_cdr_phase_ctrl.sv
module test_cdr_phase_ctrl;
  localparam int LANES = 4, CODE_W = 5, SETTLE = 2, RUN_LEN = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, burst_start, vote_valid, vote_ready, locked, tracking;
  logic [LANES-1:0]  lane_early, lane_late;
  logic [CODE_W-1:0] pi_code;

  int  total = 0, bad = 0;
  bit  auto_en = 0, done = 0;
  int  target = 0;

  cdr_phase_ctrl #(.LANES(LANES), .CODE_W(CODE_W), .SETTLE(SETTLE), .RUN_LEN(RUN_LEN))
    i_cdr_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .vote_valid(vote_valid),
    .vote_ready(vote_ready), .lane_early(lane_early), .lane_late(lane_late),
    .pi_code(pi_code), .locked(locked), .tracking(tracking));

  function automatic int wrap_err(int x);
    int y = ((x % 32) + 32) % 32;
    if (y >= 16) y -= 32;
    return y;
  endfunction

  function automatic int search_model(int t);
    int c = 16;
    for (int st = 8; st > 0; st = st / 2)
      c = (wrap_err(t - c) >= 0) ? c + st : c - st;
    return ((c % 32) + 32) % 32;
  endfunction

  // phase model: early when the target is at or ahead of the code
  always @(negedge clk) if (auto_en) begin
    vote_valid = 1'b1;
    if (wrap_err(target - int'(pi_code)) >= 0) begin lane_early = 4'hf; lane_late = 4'h0; end
    else begin lane_early = 4'h0; lane_late = 4'hf; end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] e, logic [3:0] l, logic v);
    lane_early = e; lane_late = l; vote_valid = v;
    @(negedge clk);
  endtask

  task automatic burst();
    burst_start = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; burst_start = 0; vote_valid = 0; lane_early = 0; lane_late = 0;
    repeat (3) @(negedge clk);
    chk(pi_code == 16, "R3 reset code", pi_code, 16);
    chk(!locked && !tracking, "R3 reset flags", {locked, tracking}, 0);
    chk(vote_ready == 1'b1, "R2 ready", vote_ready, 1);
    rst_n = 1;

    // search ties, empty votes and invalid beats
    for (int i = 0; i < 6; i++) drive(4'b0011, 4'b1100, 1);
    for (int i = 0; i < 3; i++) drive(4'b0000, 4'b0000, 1);
    chk(pi_code == 16 && !locked, "R9 tie stalls search", pi_code, 16);
    for (int i = 0; i < 4; i++) drive(4'hf, 4'h0, 0);
    chk(pi_code == 16, "R2 invalid ignored", pi_code, 16);

    // 3 vs 1 -> up by 8
    drive(4'b0111, 4'b1000, 1);
    chk(pi_code == 24, "R1 R4 majority up step 8", pi_code, 24);
    drive(4'hf, 4'h0, 1); drive(4'hf, 4'h0, 1);
    chk(pi_code == 24, "R5 settle ignores votes", pi_code, 24);
    drive(4'hf, 4'h0, 1);
    chk(pi_code == 28, "R4 step 4", pi_code, 28);
    drive(4'b0001, 4'b0110, 1); drive(4'b0001, 4'b0110, 1); drive(4'b0001, 4'b0110, 1);
    chk(pi_code == 26, "R1 R4 majority down step 2", pi_code, 26);
    drive(4'hf, 4'h0, 1); drive(4'hf, 4'h0, 1);
    chk(!locked && !tracking, "R6 not yet locked", locked, 0);
    drive(4'hf, 4'h0, 1);
    chk(pi_code == 27 && locked && tracking, "R6 lock after unit step", pi_code, 27);

    // tracking run
    for (int i = 0; i < 3; i++) drive(4'hf, 4'h0, 1);
    chk(pi_code == 27, "R7 run below length", pi_code, 27);
    drive(4'hf, 4'h0, 1);
    chk(pi_code == 28, "R7 run complete", pi_code, 28);

    // search to 31, then wrap
    burst();
    chk(pi_code == 16 && !locked, "R3 burst restart", pi_code, 16);
    for (int i = 0; i < 11; i++) drive(4'hf, 4'h0, 1);
    chk(pi_code == 30 && !locked, "R5 lock timing early", pi_code, 30);
    drive(4'hf, 4'h0, 1);
    chk(pi_code == 31 && locked, "R4 R6 search top", pi_code, 31);
    for (int i = 0; i < 3; i++) drive(4'hf, 4'h0, 1);
    chk(pi_code == 31, "R7 hold", pi_code, 31);
    drive(4'hf, 4'h0, 1);
    chk(pi_code == 0, "R8 wrap up", pi_code, 0);
    drive(4'h0, 4'hf, 1); drive(4'h0, 4'hf, 1);
    drive(4'b0101, 4'b1010, 1); drive(4'b0000, 4'b0000, 1);
    drive(4'hf, 4'h0, 0); drive(4'hf, 4'h0, 0);
    drive(4'h0, 4'hf, 1);
    chk(pi_code == 0, "R7 ties and gaps keep run", pi_code, 0);
    drive(4'h0, 4'hf, 1);
    chk(pi_code == 31, "R8 wrap down", pi_code, 31);
    for (int i = 0; i < 3; i++) drive(4'h0, 4'hf, 1);
    drive(4'hf, 4'h0, 1);
    for (int i = 0; i < 3; i++) drive(4'h0, 4'hf, 1);
    chk(pi_code == 31, "R7 opposite vote restarts run", pi_code, 31);
    drive(4'h0, 4'hf, 1);
    chk(pi_code == 30 && locked, "R7 R6 step after restart", pi_code, 30);

    // burst in the middle of a search
    burst();
    for (int i = 0; i < 4; i++) drive(4'hf, 4'h0, 1);
    chk(pi_code == 24, "R4 mid search", pi_code, 24);
    burst();
    chk(pi_code == 16 && !tracking, "R3 restart mid search", pi_code, 16);

    // sweep every target through the phase model
    for (int t = 0; t < 32; t++) begin
      int t2;
      auto_en = 1; target = t;
      burst();
      for (int n = 1; n <= 12; n++) begin
        @(negedge clk);
        if (n == 11) chk(!locked, "R5 no lock before edge 12", locked, 0);
      end
      chk(locked && tracking, "R6 lock at edge 12", locked, 1);
      chk(int'(pi_code) == search_model(t), "R4 search result", pi_code, search_model(t));
      t2 = (t + 11) % 32;
      target = t2;
      repeat (120) @(negedge clk);
      chk(int'(pi_code) == t2 || int'(pi_code) == (t2 + 1) % 32,
          "R7 R8 tracking follows", pi_code, t2);
      chk(locked, "R6 lock held", locked, 1);
    end
    auto_en = 0;
    summary();
  end
endmodule